// File: doc/BRIEF.md
# Byte-Lane Masked Write Register

A single storage register whose width is a parameter, written by software one or more bytes at a time. Each byte of the register is a lane with its own enable bit. When the write strobe is high at a clock edge, every lane whose enable is set takes the matching byte of the write data. Every other lane keeps its value. The whole register is always visible on the read output.

Lanes are counted from the most significant end. Enable 0 always selects the top byte, whatever the width. The data ports are declared with ascending indices, so port bit 0 is the MSB and enable n covers port bits 8n to 8n+7. Seen as an ordinary number, enable n covers value bits W-1-8n down to W-8-8n. The same code builds a 32-, 64- or 128-bit register with 4, 8 or 16 enables.

Top module: `bel_reg`

## Requirements
- R1: An active-low asynchronous reset clears every bit of the register to zero.
- R2: The register has DW/8 byte enables. DW must be a multiple of 8 and at least 8. For example, 32 bits gives 4 enables and 64 bits gives 8 enables, and every one of them can be written.
- R3: Enable n (be_i[n]) controls port bits 8n..8n+7 of wr_data_i and rd_data_o, where bit 0 is the MSB. In a numeric view this is value bits DW-1-8n down to DW-8-8n.
- R4: On a clock edge with wr_en_i high and be_i[n] set, all eight bits of lane n take the matching write-data byte.
- R5: On a write, a lane whose enable is clear keeps its previous value.
- R6: On a clock edge with wr_en_i low, the register does not change, whatever be_i and wr_data_i are.
- R7: At every width, enable 0 selects the most significant byte. The bench checks this at 64 bits as well as at 32.
- R8: rd_data_o shows the full register. A write is visible on it right after the clock edge that takes it, with no further latency.
- R9: A write with all enables set replaces the whole word. A write with no enable set leaves the word unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe |
| be_i | input | DW/8 | Byte enables; index 0 is the most significant lane |
| wr_data_i | input | DW | Write data; bit 0 is the MSB |
| rd_data_o | output | DW | Current register contents; bit 0 is the MSB |

## Verification
The assertions assume that wr_en_i, be_i and wr_data_i are stable and known at each rising clock edge. They also assume that reset is only released between edges. The bench drives every input on the falling edge and releases reset well clear of a rising edge, so those assumptions hold. The per-lane load and hold properties take the lane slicing at face value, so the bench checks the byte mapping itself by building the expected word from the numeric-view formula in R3.

// File: rtl/bel_pkg.sv
package bel_pkg;
  localparam int unsigned LANE_W = 8;
  typedef logic [LANE_W-1:0] lane_t;

  function automatic bit width_ok(int unsigned w);
    return (w >= LANE_W) && ((w % LANE_W) == 0);
  endfunction
endpackage

// File: rtl/bel_lane_decode.sv
module bel_lane_decode #(
  parameter int unsigned NB = 4
) (
  input  logic          wr_en_i,
  input  logic [0:NB-1] be_i,
  output logic [0:NB-1] ld_o
);
  for (genvar n = 0; n < NB; n++) begin : g_ld
    assign ld_o[n] = wr_en_i & be_i[n];
  end
endmodule

// File: rtl/bel_lane_store.sv
module bel_lane_store
  import bel_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  ld_i,
  input  lane_t d_i,
  output lane_t q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (ld_i) q_o <= d_i;
  end
endmodule

// File: rtl/bel_reg.sv
module bel_reg
  import bel_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [0:DW/8-1]  be_i,
  input  logic [0:DW-1]    wr_data_i,
  output logic [0:DW-1]    rd_data_o
);
  localparam int unsigned NB = DW / LANE_W;

  if (!width_ok(DW)) begin : g_bad_width
    $error("bel_reg: DW must be a multiple of 8 and at least 8");
  end

  logic [0:NB-1] ld;

  bel_lane_decode #(.NB(NB)) u_dec (
    .wr_en_i (wr_en_i),
    .be_i    (be_i),
    .ld_o    (ld)
  );

  // lane n occupies big-endian bits 8n..8n+7
  for (genvar n = 0; n < NB; n++) begin : g_lane
    lane_t q;
    bel_lane_store u_store (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .ld_i   (ld[n]),
      .d_i    (wr_data_i[n*LANE_W +: LANE_W]),
      .q_o    (q)
    );
    assign rd_data_o[n*LANE_W +: LANE_W] = q;
  end
endmodule

// File: rtl/bel_reg_chk.sv
module bel_reg_chk #(
  parameter int unsigned DW = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            wr_en_i,
  input logic [0:DW/8-1] be_i,
  input logic [0:DW-1]   wr_data_i,
  input logic [0:DW-1]   rd_data_o
);
  localparam int unsigned NB = DW / 8;

  AST_RESET_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (rd_data_o == '0)); // R1

  AST_NO_STROBE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(rd_data_o)); // R6

  for (genvar n = 0; n < NB; n++) begin : g_lane
    AST_LANE_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && be_i[n]) |=>
        (rd_data_o[n*8 +: 8] == $past(wr_data_i[n*8 +: 8]))); // R4

    AST_LANE_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && !be_i[n]) |=> $stable(rd_data_o[n*8 +: 8])); // R5
  end
endmodule

bind bel_reg bel_reg_chk #(.DW(DW)) u_chk (.*);

// File: tb/sim_bel_reg.sv
`timescale 1ns/1ps
module sim_bel_reg;
  localparam int unsigned DW = 32;
  localparam int unsigned NB = DW / 8;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic wr_en_i = 1'b0;
  logic [0:NB-1] be_i = '0;
  logic [0:DW-1] wr_data_i = '0;
  logic [0:DW-1] rd_data_o;

  logic wr1 = 1'b0;
  logic [0:7] be1 = '0;
  logic [0:63] wd1 = '0;
  logic [0:63] rd1;

  always #5 clk_i = ~clk_i;

  bel_reg #(.DW(DW)) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i),
    .be_i(be_i), .wr_data_i(wr_data_i), .rd_data_o(rd_data_o)
  );

  bel_reg #(.DW(64)) u1 (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr1),
    .be_i(be1), .wr_data_i(wd1), .rd_data_o(rd1)
  );

  typedef struct {
    logic [31:0] exp;
    string       req;
  } item_t;

  item_t sb_q[$];
  logic [31:0] model = '0;
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  task automatic report;
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  task automatic check32(logic [31:0] act, logic [31:0] exp, string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check64(logic [63:0] act, logic [63:0] exp, string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // driver: applies one cycle, updates the model and queues the expected word
  task automatic drive(logic en, logic [0:NB-1] be, logic [31:0] d, string req);
    item_t it;
    @(negedge clk_i);
    wr_en_i   = en;
    be_i      = be;
    wr_data_i = d;
    if (en) begin
      for (int n = 0; n < int'(NB); n++)
        if (be[n]) model[DW-1-8*n -: 8] = d[DW-1-8*n -: 8]; // R3 numeric view
    end
    @(posedge clk_i);
    #1;
    it.exp = model;
    it.req = req;
    sb_q.push_back(it);
  endtask

  // monitor: compares on the falling edge after each write edge
  initial begin
    forever begin
      @(negedge clk_i);
      if (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        check32(rd_data_o, it.exp, it.req);
      end
    end
  end

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    report();
  end

  initial begin
    #22;
    check32(rd_data_o, 32'h0, "R1");
    check64(rd1, 64'h0, "R1");
    rst_ni = 1'b1;

    drive(1'b1, 4'b1111, 32'hDEADBEEF, "R9");
    drive(1'b1, 4'b1000, 32'h11223344, "R3");
    drive(1'b1, 4'b0001, 32'h55667788, "R3");
    drive(1'b1, 4'b0110, 32'hA5A5A5A5, "R4");
    drive(1'b1, 4'b0100, 32'h00FF0000, "R5");
    drive(1'b0, 4'b1111, 32'h00000000, "R6");
    drive(1'b0, 4'b0101, 32'h12345678, "R6");
    drive(1'b1, 4'b0000, 32'hFFFFFFFF, "R9");
    for (int n = 0; n < int'(NB); n++) begin
      logic [0:NB-1] b;
      b = '0;
      b[n] = 1'b1;
      drive(1'b1, b, 32'h0F1E2D3C ^ (32'h01010101 << n), "R8");
    end
    drive(1'b1, 4'b1010, 32'hC3C3C3C3, "R5");
    drive(1'b0, 4'b0000, 32'h0, "R6");
    repeat (2) @(negedge clk_i);

    // 64-bit instance: enable 0 still hits the top byte
    wd1 = 64'h1122334455667788;
    be1 = 8'b1000_0000;
    wr1 = 1'b1;
    @(negedge clk_i);
    wr1 = 1'b0;
    check64(rd1, 64'h1100000000000000, "R7");
    wd1 = 64'hAAAAAAAAAAAAAAAA;
    be1 = 8'b0000_0001;
    wr1 = 1'b1;
    @(negedge clk_i);
    wr1 = 1'b0;
    check64(rd1, 64'h11000000000000AA, "R2");

    // reset after activity clears both widths
    #2 rst_ni = 1'b0;
    #1;
    check32(rd_data_o, 32'h0, "R1");
    check64(rd1, 64'h0, "R1");
    model = '0;
    #4 rst_ni = 1'b1;
    drive(1'b1, 4'b0010, 32'h00009900, "R4");
    repeat (3) @(negedge clk_i);
    report();
  end
endmodule